// File: doc/BRIEF.md
# Serial Receive Queue and Interrupt Register Bank

This block is the host-facing half of a serial port. A bus master reaches it through single-cycle read and write strobes, a 12-bit byte offset and 32-bit data. Characters from a line receiver arrive on a valid/ready byte stream and are held in a circular queue until the host reads them. A received line break is stored in the queue as a tagged entry. A host write to the data register places the low byte on a one-cycle transmit strobe and raises the transmit interrupt. The block also holds raw and masked interrupt status, a mask and a write-one-to-clear acknowledge, which together drive one level-sensitive interrupt pin. It keeps a set of plain storage registers for baud divisors, line and control settings, and it answers a read-only identification window.

Read data is combinational from the offset during the cycle in which the read strobe is high. The side effects of a data read (popping the queue, updating the flags and the interrupt) take place at the clock edge that ends that cycle. When a pop and a push fall on the same edge, the pop is applied first and the push second.

Top module: `uart_rx_regbank`

## Requirements
- R1: After reset the flag word (index 6) reads 0x90, control (index 12) reads 0x300, level select (index 13) reads 0x12, raw status (index 15) reads 0, `irq` and `tx_strobe` are 0 and `rx_ready` is 1.
- R2: The storage registers read back what was written, truncated to their widths: index 8 keeps 8 bits, index 9 keeps 16, index 10 keeps 6, index 11 keeps 8, index 12 keeps 16, index 13 keeps 6 and index 18 keeps 3. The register index is the byte offset shifted right by two.
- R3: Offsets 0xFE0 to 0xFFC read identification bytes, one per word, in the order 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. The byte is chosen by offset bits [4:2].
- R4: While line-control bit 4 is set, `rx_ready` stays high until 16 entries are held. A read of index 0 returns the oldest entry, zero-extended, and the order holds across the wrap of the read position.
- R5: While line-control bit 4 is clear, `rx_ready` is high only when the queue is empty.
- R6: Flag bit 4 (receive empty) is cleared by a push and set when a read leaves the queue empty. Flag bit 6 (receive full) is set by a push that brings the count to 16, or by any push while control bit 4 is set, and is cleared by a data read. Bit 7 reads 1, bit 5 reads 0, and writes to the flag index change nothing.
- R7: A push with `rx_break` high stores the entry 0x400 in place of the data byte.
- R8: Raw status bit 4 is set by a push that brings the count to the trigger level (1). It is cleared by a data read that leaves the count at one below the trigger level, and stays set while the count is above that.
- R9: A write to index 0 drives `tx_strobe` high with `tx_byte` equal to the written low byte during the write cycle, and sets raw status bit 5.
- R10: Index 14 holds the interrupt mask. Index 16 reads raw status ANDed with the mask, and `irq` is high exactly when that result is nonzero.
- R11: A write to index 17 clears every raw status bit that is 1 in the written value and leaves the others unchanged.
- R12: A data read of an empty queue returns the entry at the current read position and moves neither the position nor the count. Offsets outside the map read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| rx_valid | input | 1 | Received character or break present |
| rx_break | input | 1 | Marks the offered item as a line break |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | The queue can take an item this cycle |
| tx_strobe | output | 1 | A byte is being sent |
| tx_byte | output | 8 | Byte being sent |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the wrap of the circular queue while it is completely full. Here the write slot and the read position coincide and the full flag comes from the count alone. Earlier sequences leave the read position at a nonzero offset: single pushes and pops, a break entry and a pop on an empty queue. The stimulus then enables deep mode and pushes sixteen distinct bytes, so the queue fills across its end. Draining it checks both the order of the entries and the point at which the full flag and the receive interrupt drop.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int ENTRY_W = 11;
   localparam int IRQ_W   = 11;
   localparam int IDX_W   = 10;

   localparam logic [ENTRY_W-1:0] BREAK_ENTRY = 11'h400;

   localparam int IRQ_RX_BIT = 4;
   localparam int IRQ_TX_BIT = 5;

   localparam logic [IDX_W-1:0] IDX_DATA  = 10'd0;
   localparam logic [IDX_W-1:0] IDX_FLAG  = 10'd6;
   localparam logic [IDX_W-1:0] IDX_LPDIV = 10'd8;
   localparam logic [IDX_W-1:0] IDX_IDIV  = 10'd9;
   localparam logic [IDX_W-1:0] IDX_FDIV  = 10'd10;
   localparam logic [IDX_W-1:0] IDX_LINE  = 10'd11;
   localparam logic [IDX_W-1:0] IDX_CTRL  = 10'd12;
   localparam logic [IDX_W-1:0] IDX_LVL   = 10'd13;
   localparam logic [IDX_W-1:0] IDX_MASK  = 10'd14;
   localparam logic [IDX_W-1:0] IDX_RAW   = 10'd15;
   localparam logic [IDX_W-1:0] IDX_MSKD  = 10'd16;
   localparam logic [IDX_W-1:0] IDX_CLR   = 10'd17;
   localparam logic [IDX_W-1:0] IDX_DMA   = 10'd18;

   localparam logic [15:0] CTRL_RESET = 16'h0300;
   localparam logic [5:0]  LVL_RESET  = 6'h12;
endpackage

// File: rtl/uart_rx_idrom.sv
module uart_rx_idrom #(
   parameter int VARIANT = 0
) (
   input  logic [2:0] sel,
   output logic [7:0] id_byte
);
   if (VARIANT < 0 || VARIANT > 1) begin : g_bad_variant
      $error("uart_rx_idrom: VARIANT must be 0 or 1");
   end

   if (VARIANT == 0) begin : g_std
      always_comb begin
         case (sel)
            3'd0: id_byte = 8'h11;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h14;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
         endcase
      end
   end else begin : g_alt
      always_comb begin
         case (sel)
            3'd0: id_byte = 8'h11;
            3'd1: id_byte = 8'h00;
            3'd2: id_byte = 8'h18;
            3'd3: id_byte = 8'h01;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 11,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rptr;
   logic [PTR_W-1:0]  wslot;
   logic              pop_eff;

   assign pop_eff = pop && (count != '0);
   // Pop-then-push: advancing rptr and shrinking count cancel, slot unchanged.
   assign wslot   = rptr + count[PTR_W-1:0];
   assign rdata   = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) mem[wslot] <= wdata;
         if (pop_eff) rptr <= rptr + 1'b1;
         count <= count - {{(CNT_W-1){1'b0}}, pop_eff} + {{(CNT_W-1){1'b0}}, push};
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH))); // R4
   AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count != '0) |=> (rptr == $past(rptr) + 1'b1)); // R4
   AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count == '0 && !push) |=> ($stable(rptr) && count == '0)); // R12
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq #(
   parameter int TRIG  = 1,
   parameter int CNT_W = 5,
   parameter int IRQ_W = 11,
   parameter int RX_B  = 4,
   parameter int TX_B  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_push,
   input  logic             data_rd,
   input  logic [CNT_W-1:0] cnt_mid,
   input  logic [CNT_W-1:0] cnt_next,
   input  logic             tx_write,
   input  logic             clr_write,
   input  logic [IRQ_W-1:0] clr_val,
   output logic [IRQ_W-1:0] raw
);
   logic [IRQ_W-1:0] raw_n;

   always_comb begin
      raw_n = raw;
      if (data_rd && cnt_mid == CNT_W'(TRIG - 1)) raw_n[RX_B] = 1'b0;
      if (clr_write) raw_n = raw_n & ~clr_val;
      if (tx_write) raw_n[TX_B] = 1'b1;
      if (rx_push && cnt_next == CNT_W'(TRIG)) raw_n[RX_B] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw <= '0;
      else        raw <= raw_n;
   end

   AST_RX_RISES_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[RX_B]) |-> $past(rx_push)); // R8
   AST_TX_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_write |=> raw[TX_B]); // R9
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_write && !tx_write && !rx_push) |=> ((raw & $past(clr_val)) == '0)); // R11
endmodule

// File: rtl/uart_rx_regbank.sv
module uart_rx_regbank
   import uart_rx_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int RX_TRIGGER = 1,
   parameter int ID_VARIANT = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [11:0] bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        rx_valid,
   input  logic        rx_break,
   input  logic [7:0]  rx_data,
   output logic        rx_ready,
   output logic        tx_strobe,
   output logic [7:0]  tx_byte,
   output logic        irq
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rx_regbank: FIFO_DEPTH must be a power of two, at least 2");
   end
   if (RX_TRIGGER < 1 || RX_TRIGGER > FIFO_DEPTH) begin : g_bad_trig
      $error("uart_rx_regbank: RX_TRIGGER must lie in 1..FIFO_DEPTH");
   end

   logic [IDX_W-1:0]   idx;
   logic               in_id;
   logic               data_wr, data_rd, clr_wr, rx_push, pop_eff;
   logic [7:0]         lpdiv_q, line_q;
   logic [15:0]        idiv_q, ctrl_q;
   logic [5:0]         fdiv_q, lvl_q;
   logic [2:0]         dma_q;
   logic [IRQ_W-1:0]   mask_q, raw;
   logic               rxfe_q, rxff_q;
   logic [ENTRY_W-1:0] push_entry, fifo_rd;
   logic [CNT_W-1:0]   count, cnt_mid, cnt_next;
   logic [7:0]         id_byte;
   logic [7:0]         flag_word;
   logic               unused_bits;

   assign unused_bits = ^{bus_wdata[31:16], bus_addr[1:0]};

   assign idx     = bus_addr[11:2];
   assign in_id   = &bus_addr[11:5];
   assign data_wr = bus_wr && !in_id && idx == IDX_DATA;
   assign clr_wr  = bus_wr && !in_id && idx == IDX_CLR;
   assign data_rd = bus_rd && !in_id && idx == IDX_DATA;

   assign rx_ready   = line_q[4] ? (count < CNT_W'(FIFO_DEPTH)) : (count == '0);
   assign rx_push    = rx_valid && rx_ready;
   assign push_entry = rx_break ? BREAK_ENTRY : {{(ENTRY_W-8){1'b0}}, rx_data};
   assign pop_eff    = data_rd && (count != '0);
   assign cnt_mid    = count - {{(CNT_W-1){1'b0}}, pop_eff};
   assign cnt_next   = cnt_mid + {{(CNT_W-1){1'b0}}, rx_push};

   assign tx_strobe = data_wr;
   assign tx_byte   = bus_wdata[7:0];
   assign irq       = |(raw & mask_q);

   uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(ENTRY_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(data_rd),
      .wdata(push_entry), .rdata(fifo_rd), .count(count)
   );

   uart_rx_irq #(.TRIG(RX_TRIGGER), .CNT_W(CNT_W), .IRQ_W(IRQ_W),
                 .RX_B(IRQ_RX_BIT), .TX_B(IRQ_TX_BIT)) u_irq (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .data_rd(data_rd),
      .cnt_mid(cnt_mid), .cnt_next(cnt_next), .tx_write(data_wr),
      .clr_write(clr_wr), .clr_val(bus_wdata[IRQ_W-1:0]), .raw(raw)
   );

   uart_rx_idrom #(.VARIANT(ID_VARIANT)) u_id (.sel(bus_addr[4:2]), .id_byte(id_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lpdiv_q <= '0;
         idiv_q  <= '0;
         fdiv_q  <= '0;
         line_q  <= '0;
         ctrl_q  <= CTRL_RESET;
         lvl_q   <= LVL_RESET;
         mask_q  <= '0;
         dma_q   <= '0;
      end else if (bus_wr && !in_id) begin
         case (idx)
            IDX_LPDIV: lpdiv_q <= bus_wdata[7:0];
            IDX_IDIV:  idiv_q  <= bus_wdata[15:0];
            IDX_FDIV:  fdiv_q  <= bus_wdata[5:0];
            IDX_LINE:  line_q  <= bus_wdata[7:0];
            IDX_CTRL:  ctrl_q  <= bus_wdata[15:0];
            IDX_LVL:   lvl_q   <= bus_wdata[5:0];
            IDX_MASK:  mask_q  <= bus_wdata[IRQ_W-1:0];
            IDX_DMA:   dma_q   <= bus_wdata[2:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxfe_q <= 1'b1;
         rxff_q <= 1'b0;
      end else begin
         if (rx_push) rxfe_q <= 1'b0;
         else if (data_rd && cnt_mid == '0) rxfe_q <= 1'b1;
         if (rx_push && (cnt_next == CNT_W'(FIFO_DEPTH) || ctrl_q[4])) rxff_q <= 1'b1;
         else if (data_rd) rxff_q <= 1'b0;
      end
   end

   assign flag_word = {1'b1, rxff_q, 1'b0, rxfe_q, 4'b0000};

   always_comb begin
      bus_rdata = '0;
      if (in_id) bus_rdata = {24'b0, id_byte};
      else begin
         case (idx)
            IDX_DATA:  bus_rdata = 32'(fifo_rd);
            IDX_FLAG:  bus_rdata = {24'b0, flag_word};
            IDX_LPDIV: bus_rdata = {24'b0, lpdiv_q};
            IDX_IDIV:  bus_rdata = {16'b0, idiv_q};
            IDX_FDIV:  bus_rdata = {26'b0, fdiv_q};
            IDX_LINE:  bus_rdata = {24'b0, line_q};
            IDX_CTRL:  bus_rdata = {16'b0, ctrl_q};
            IDX_LVL:   bus_rdata = {26'b0, lvl_q};
            IDX_MASK:  bus_rdata = 32'(mask_q);
            IDX_RAW:   bus_rdata = 32'(raw);
            IDX_MSKD:  bus_rdata = 32'(raw & mask_q);
            IDX_DMA:   bus_rdata = {29'b0, dma_q};
            default:   bus_rdata = '0;
         endcase
      end
   end

   AST_EMPTY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      rxfe_q == (count == '0)); // R6
   AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(FIFO_DEPTH)) |-> (rxff_q && !rx_ready)); // R4
endmodule

// File: tb/sim_uart_rx_regbank.sv
`timescale 1ns/1ps
module sim_uart_rx_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0, rx_break = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_strobe, irq;
   logic [7:0]  tx_byte;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   uart_rx_regbank u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
      .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
   );

   // op[81:80] 0=write 1=read-check 2=push byte 3=push break
   // addr[79:68] data[67:36] expected[35:4] requirement[3:0]
   localparam int NV = 38;
   localparam logic [81:0] VEC [0:NV-1] = '{
      {2'd1, 12'h018, 32'h0, 32'h90, 4'd1},          // R1 flags
      {2'd1, 12'h030, 32'h0, 32'h300, 4'd1},         // R1 control
      {2'd1, 12'h034, 32'h0, 32'h12, 4'd1},          // R1 level select
      {2'd1, 12'h03C, 32'h0, 32'h0, 4'd1},           // R1 raw status
      {2'd0, 12'h020, 32'hFFFFFFAB, 32'h0, 4'd2},    // R2
      {2'd1, 12'h020, 32'h0, 32'hAB, 4'd2},          // R2 8-bit
      {2'd0, 12'h024, 32'h12345678, 32'h0, 4'd2},    // R2
      {2'd1, 12'h024, 32'h0, 32'h5678, 4'd2},        // R2 16-bit
      {2'd0, 12'h028, 32'hFF, 32'h0, 4'd2},          // R2
      {2'd1, 12'h028, 32'h0, 32'h3F, 4'd2},          // R2 6-bit
      {2'd0, 12'h048, 32'hF, 32'h0, 4'd2},           // R2
      {2'd1, 12'h048, 32'h0, 32'h7, 4'd2},           // R2 3-bit
      {2'd1, 12'hFE0, 32'h0, 32'h11, 4'd3},          // R3
      {2'd1, 12'hFE8, 32'h0, 32'h14, 4'd3},          // R3
      {2'd1, 12'hFFC, 32'h0, 32'hB1, 4'd3},          // R3
      {2'd0, 12'h018, 32'h0, 32'h0, 4'd6},           // R6 write flags
      {2'd1, 12'h018, 32'h0, 32'h90, 4'd6},          // R6 unchanged
      {2'd0, 12'h004, 32'h55, 32'h0, 4'd12},         // R12 unmapped write
      {2'd1, 12'h004, 32'h0, 32'h0, 4'd12},          // R12
      {2'd1, 12'h044, 32'h0, 32'h0, 4'd12},          // R12 clear index reads 0
      {2'd0, 12'h038, 32'h30, 32'h0, 4'd10},         // R10 mask
      {2'd1, 12'h038, 32'h0, 32'h30, 4'd10},         // R10
      {2'd2, 12'h000, 32'h41, 32'h0, 4'd4},          // R4 push
      {2'd1, 12'h018, 32'h0, 32'h80, 4'd6},          // R6 not empty
      {2'd1, 12'h03C, 32'h0, 32'h10, 4'd8},          // R8 raised
      {2'd1, 12'h040, 32'h0, 32'h10, 4'd10},         // R10 masked
      {2'd1, 12'h000, 32'h0, 32'h41, 4'd4},          // R4 pop
      {2'd1, 12'h03C, 32'h0, 32'h0, 4'd8},           // R8 dropped
      {2'd1, 12'h018, 32'h0, 32'h90, 4'd6},          // R6 empty again
      {2'd3, 12'h000, 32'h0, 32'h0, 4'd7},           // R7 break
      {2'd1, 12'h000, 32'h0, 32'h400, 4'd7},         // R7
      {2'd1, 12'h000, 32'h0, 32'h0, 4'd12},          // R12 stale slot 2
      {2'd1, 12'h018, 32'h0, 32'h90, 4'd12},         // R12 still empty
      {2'd0, 12'h000, 32'h1C3, 32'h0, 4'd9},         // R9 send
      {2'd1, 12'h03C, 32'h0, 32'h20, 4'd9},          // R9
      {2'd0, 12'h044, 32'h20, 32'h0, 4'd11},         // R11 clear
      {2'd1, 12'h03C, 32'h0, 32'h0, 4'd11},          // R11
      {2'd0, 12'h038, 32'h0, 32'h0, 4'd10}           // R10 mask off
   };

   task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic read_check(input int req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(req, $sformatf("read %h", a), d, exp);
   endtask

   task automatic push(input logic [7:0] b, input logic brk);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; rx_break = brk;
      @(negedge clk);
      rx_valid = 1'b0; rx_break = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(1, "irq after reset", {31'b0, irq}, 32'h0);             // R1
      check(1, "rx_ready after reset", {31'b0, rx_ready}, 32'h1);   // R1
      check(1, "tx_strobe idle", {31'b0, tx_strobe}, 32'h0);        // R1

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][81:80])
            2'd0: bus_write(VEC[i][79:68], VEC[i][67:36]);
            2'd1: read_check(int'(VEC[i][3:0]), VEC[i][79:68], VEC[i][35:4]);
            2'd2: push(VEC[i][43:36], 1'b0);
            default: push(8'h00, 1'b1);
         endcase
      end

      // R5: shallow mode holds one entry
      push(8'h5A, 1'b0);
      #1 check(5, "ready with one entry, shallow", {31'b0, rx_ready}, 32'h0);
      read_check(4, 12'h000, 32'h5A);
      #1 check(5, "ready after drain, shallow", {31'b0, rx_ready}, 32'h1);

      // R4: deep mode, fill across the wrap
      bus_write(12'h02C, 32'h10);
      for (int i = 0; i < 16; i++) begin
         if (!rx_ready) check(4, "ready before full", 32'h0, 32'h1);
         push(8'(8'h20 + i), 1'b0);
      end
      #1 check(4, "ready when full", {31'b0, rx_ready}, 32'h0);
      read_check(6, 12'h018, 32'hC0);   // R6 full by count
      read_check(8, 12'h03C, 32'h10);   // R8
      for (int i = 0; i < 16; i++) begin
         read_check(4, 12'h000, 32'(8'h20 + i));
         if (i == 0) begin
            read_check(6, 12'h018, 32'h80);  // R6 full cleared by read
            read_check(8, 12'h03C, 32'h10);  // R8 held above trigger-1
         end
      end
      read_check(6, 12'h018, 32'h90);
      read_check(8, 12'h03C, 32'h0);

      // R6: control bit 4 forces full on push
      bus_write(12'h030, 32'h310);
      push(8'h07, 1'b0);
      read_check(6, 12'h018, 32'hC0);
      read_check(6, 12'h000, 32'h07);
      read_check(6, 12'h018, 32'h90);
      bus_write(12'h030, 32'h300);

      // R10: pin follows masked status
      bus_write(12'h038, 32'h10);
      push(8'h01, 1'b0);
      #1 check(10, "irq masked-in rx", {31'b0, irq}, 32'h1);
      bus_read(12'h000, d);
      #1 check(10, "irq after drain", {31'b0, irq}, 32'h0);
      bus_write(12'h038, 32'h0);
      push(8'h03, 1'b0);
      #1 check(10, "irq masked-out", {31'b0, irq}, 32'h0);
      read_check(10, 12'h040, 32'h0);
      bus_read(12'h000, d);

      // R9 and R11: strobe and selective clear
      push(8'h02, 1'b0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'hAAAA_55C3;
      #1 check(9, "tx strobe/byte", {23'b0, tx_strobe, tx_byte}, 32'h1C3);
      @(negedge clk);
      bus_wr = 1'b0;
      read_check(9, 12'h03C, 32'h30);
      bus_write(12'h044, 32'h20);
      read_check(11, 12'h03C, 32'h10);
      read_check(11, 12'h000, 32'h02);
      read_check(11, 12'h03C, 32'h0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule